// File: doc/BRIEF.md
# Dual-Channel Simultaneous Sampling Sequencer

This block is the digital control sequencer of a two-bank converter. Bank A and bank B each have eight inputs. One pair with the same index in both banks is sampled at the same instant. A start request can come from a PWM event, a software write or an external pin. When the sequencer is idle, the request is accepted. The sequencer then latches the 3-bit pair index and the 4-bit acquisition setting. Half a clock after the second rising edge it raises the sample/hold strobe, and the strobe stays high for (1 + acquisition setting) clocks.

Both analog inputs are held on the falling edge of the strobe. The conversion core is outside this block. It returns the two converted values on separate data inputs. The sequencer writes the A result and then, one clock later, the B result into its result registers. Two clocks after the B write it sets a sticky interrupt flag. In continuous mode the sequencer starts a new pair every (3 + acquisition setting) clocks for as long as the continuous input is high at the end of each period. A start request that arrives while a pair is still being handled is dropped, and a sticky overflow flag is set.

All timing below counts rising clock edges. Edge k is the edge at which a start request is accepted.

Top module: `dual_sh_seq`

## Requirements
- R1: A high level on any of `trig_pwm_i`, `trig_sw_i` or `trig_ext_i` at a rising edge, while the block is idle, starts a pair conversion. From that edge on, `ch_o` shows the value of `ch_i` sampled at that edge. `ch_o` is the single 3-bit index that drives both bank multiplexers.
- R2: The pair index and the acquisition setting are taken only when a request is accepted. Later changes of `ch_i` and `acq_i` do not affect `ch_o`, the strobe width or the result timing of a pair already in progress.
- R3: `hold_o` rises on the falling clock edge after edge k+2. It falls on the falling clock edge after edge k+3+ACQ, where ACQ (0 to 15) is the accepted `acq_i`. Seen just after the rising edges, it is high after edges k+3 through k+3+ACQ, which is 1+ACQ clocks. It is never high for more than 16 clocks in a row.
- R4: At edge k+7+ACQ, which is the fourth rising edge after `hold_o` falls, `res_a_o` loads `a_data_i`. `a_upd_o` is high for the one cycle that follows.
- R5: At edge k+8+ACQ, `res_b_o` loads `b_data_i`. `b_upd_o` is high for the one cycle that follows, so it always comes exactly one clock after `a_upd_o`.
- R6: `irq_o` is set at edge k+10+ACQ, which is two edges after the B write. It stays set until `irq_clr_i` is high at a rising edge. If a set and a clear fall on the same edge, the set wins.
- R7: A start request at any edge from k+1 through k+8+ACQ is ignored: `ch_o` and the result timing do not change. Such a request sets `ovf_o` at that edge. A request at edge k+9+ACQ is accepted. `ovf_o` stays set until `ovf_clr_i` is high at a rising edge, and a new overflow on the same edge wins over the clear.
- R8: While `cont_i` is high at each period end (edge k+3+ACQ after each period start), a new period starts at that edge. Strobes and both result writes then repeat every 3+ACQ clocks. When `cont_i` is low at a period end, no new period starts.
- R9: During and just after reset, `hold_o`, `ch_o`, `res_a_o`, `res_b_o`, `a_upd_o`, `b_upd_o`, `irq_o` and `ovf_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_pwm_i | input | 1 | Start request from a PWM event |
| trig_sw_i | input | 1 | Start request from a software write |
| trig_ext_i | input | 1 | Start request from the external pin |
| ch_i | input | CW (3) | Pair index, sampled when a request is accepted |
| acq_i | input | AW (4) | Acquisition setting ACQ, sampled when a request is accepted |
| cont_i | input | 1 | Continuous mode, checked at each period end |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| a_data_i | input | DW (12) | Converted value of the bank A channel |
| b_data_i | input | DW (12) | Converted value of the bank B channel |
| ch_o | output | CW (3) | Pair index driving both bank multiplexers |
| hold_o | output | 1 | Sample/hold strobe; a falling edge holds both inputs |
| res_a_o | output | DW (12) | Bank A result register |
| res_b_o | output | DW (12) | Bank B result register |
| a_upd_o | output | 1 | One-cycle pulse after an A result write |
| b_upd_o | output | 1 | One-cycle pulse after a B result write |
| irq_o | output | 1 | Sticky interrupt flag |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Single pairs are started from each of the three request sources with random index and acquisition settings. Measuring the strobe position and width against ACQ separates an acquisition-width error from an offset in the A, B or interrupt timing. Extra requests are injected at the last ignored edge and at the first accepted edge, and index and acquisition changes are made with no request. These cases tell a correct busy window from one that is off by one, and show whether parameters are latched only when a request is accepted. A continuous run with a request injected part-way checks the repeat interval, the number of periods after the continuous input drops, and the overflow flag. A behavioural core returns a fresh random value pair on every strobe fall, so data taken at the wrong edge shows up as a mismatch.

// File: rtl/dual_sh_seq.sv
module dual_sh_seq #(
  parameter int DW = 12,
  parameter int AW = 4,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_pwm_i,
  input  logic          trig_sw_i,
  input  logic          trig_ext_i,
  input  logic [CW-1:0] ch_i,
  input  logic [AW-1:0] acq_i,
  input  logic          cont_i,
  input  logic          irq_clr_i,
  input  logic          ovf_clr_i,
  input  logic [DW-1:0] a_data_i,
  input  logic [DW-1:0] b_data_i,
  output logic [CW-1:0] ch_o,
  output logic          hold_o,
  output logic [DW-1:0] res_a_o,
  output logic [DW-1:0] res_b_o,
  output logic          a_upd_o,
  output logic          b_upd_o,
  output logic          irq_o,
  output logic          ovf_o
);
  localparam int CNTW = AW + 2;
  localparam int PIPE = 6;
  localparam int A_TAP = 2;
  localparam int B_TAP = 3;
  localparam int I_TAP = 5;

  logic            trig, busy, accept, run, run_nxt, period_end, sh_req, sh_nxt;
  logic            hold_q, hold_d, fall;
  logic [CNTW-1:0] cnt, cnt_nxt;
  logic [AW-1:0]   acq_r;
  logic [CW-1:0]   ch_r;
  logic [PIPE-1:0] pipe;

  assign trig       = trig_pwm_i | trig_sw_i | trig_ext_i;
  assign busy       = run | hold_d | (|pipe[B_TAP:0]);
  assign accept     = trig & ~busy;
  assign period_end = run & (cnt == CNTW'(acq_r) + CNTW'(2));
  assign run_nxt    = accept | (run & ~(period_end & ~cont_i));
  assign cnt_nxt    = (accept | period_end) ? '0 : cnt + CNTW'(1);
  assign sh_nxt     = run_nxt & (cnt_nxt >= CNTW'(2)) &
                      (cnt_nxt <= CNTW'(acq_r) + CNTW'(2));
  assign fall       = hold_d & ~hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      cnt    <= '0;
      acq_r  <= '0;
      ch_r   <= '0;
      sh_req <= 1'b0;
    end else begin
      run    <= run_nxt;
      cnt    <= run_nxt ? cnt_nxt : '0;
      sh_req <= sh_nxt;
      if (accept) begin
        acq_r <= acq_i;
        ch_r  <= ch_i;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= sh_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_d  <= 1'b0;
      pipe    <= '0;
      res_a_o <= '0;
      res_b_o <= '0;
      a_upd_o <= 1'b0;
      b_upd_o <= 1'b0;
      irq_o   <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      hold_d  <= hold_q;
      pipe    <= {pipe[PIPE-2:0], fall};
      a_upd_o <= pipe[A_TAP];
      b_upd_o <= pipe[B_TAP];
      if (pipe[A_TAP]) res_a_o <= a_data_i;
      if (pipe[B_TAP]) res_b_o <= b_data_i;
      if (pipe[I_TAP])    irq_o <= 1'b1;
      else if (irq_clr_i) irq_o <= 1'b0;
      if (trig & busy)    ovf_o <= 1'b1;
      else if (ovf_clr_i) ovf_o <= 1'b0;
    end
  end

  assign ch_o   = ch_r;
  assign hold_o = hold_q;
endmodule

// File: rtl/dual_sh_seq_chk.sv
module dual_sh_seq_chk #(
  parameter int AW = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trig,
  input logic          busy,
  input logic          hold_o,
  input logic [CW-1:0] ch_i,
  input logic [CW-1:0] ch_o,
  input logic          a_upd_o,
  input logic          b_upd_o,
  input logic          irq_o,
  input logic          irq_clr_i,
  input logic          ovf_o,
  input logic          ovf_clr_i
);
  localparam int HW = AW + 2;
  logic [HW-1:0] hw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hw <= '0;
    else if (hold_o) hw <= hw + HW'(1);
    else             hw <= '0;
  end

  assert_accept_ch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !busy) |=> (ch_o == $past(ch_i)));
  assert_ch_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ch_o));
  assert_hold_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hw <= HW'(1 << AW));
  assert_b_after_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    a_upd_o |=> b_upd_o);
  assert_irq_after_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    b_upd_o |-> ##2 irq_o);
  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr_i) |=> irq_o);
  assert_ovf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && busy) |=> ovf_o);
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
endmodule

bind dual_sh_seq dual_sh_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .busy(busy), .hold_o(hold_o),
  .ch_i(ch_i), .ch_o(ch_o), .a_upd_o(a_upd_o), .b_upd_o(b_upd_o),
  .irq_o(irq_o), .irq_clr_i(irq_clr_i), .ovf_o(ovf_o), .ovf_clr_i(ovf_clr_i)
);

// File: tb/dual_sh_seq_tb.sv
`timescale 1ns/1ps
module dual_sh_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic trig_pwm_i = 0, trig_sw_i = 0, trig_ext_i = 0, cont_i = 0;
  logic irq_clr_i = 0, ovf_clr_i = 0;
  logic [2:0] ch_i = '0;
  logic [3:0] acq_i = '0;
  logic [11:0] a_data_i = '0, b_data_i = '0;
  logic [2:0] ch_o;
  logic hold_o, a_upd_o, b_upd_o, irq_o, ovf_o;
  logic [11:0] res_a_o, res_b_o;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [11:0] qa[$], qb[$];
  logic [11:0] va, vb;

  dual_sh_seq u_dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_a(input int acq); return 7 + acq; endfunction
  function automatic int exp_b(input int acq); return 8 + acq; endfunction
  function automatic int exp_i(input int acq); return 10 + acq; endfunction

  // behavioural conversion core: new value pair per hold fall
  always @(negedge hold_o) if (rst_n) begin
    va = 12'($urandom);
    vb = 12'($urandom);
    qa.push_back(va);
    qb.push_back(vb);
    fork
      begin
        automatic logic [11:0] ma = va;
        automatic logic [11:0] mb = vb;
        repeat (3) @(posedge clk);
        @(negedge clk) a_data_i = ma;
        @(posedge clk);
        @(negedge clk) b_data_i = mb;
      end
    join_none
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && a_upd_o) begin
      if (qa.size() == 0) chk(0, "R4", "unexpected A write", 1, 0);
      else begin
        logic [11:0] e;
        e = qa.pop_front();
        chk(res_a_o == e, "R4", "A result value", res_a_o, e);
      end
    end
    if (rst_n && b_upd_o) begin
      if (qb.size() == 0) chk(0, "R5", "unexpected B write", 1, 0);
      else begin
        logic [11:0] e;
        e = qb.pop_front();
        chk(res_b_o == e, "R5", "B result value", res_b_o, e);
      end
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic clear_flags();
    irq_clr_i = 1; ovf_clr_i = 1; tick();
    irq_clr_i = 0; ovf_clr_i = 0;
    chk(irq_o == 0, "R6", "irq after clear", irq_o, 0);
    chk(ovf_o == 0, "R7", "ovf after clear", ovf_o, 0);
  endtask

  // kind: 0 plain, 1 request mid-pair, 2 request at last busy edge,
  //       3 request at first free edge, 4 index/acq change without request
  task automatic run_pair(input int ch, input int acq, input int src, input int kind);
    int fh = -1, nh = 0, ja = -1, jb = -1, ji = -1, len;
    int nch;
    len = 16 + acq;
    nch = (ch + 1) % 8;
    ch_i = 3'(ch); acq_i = 4'(acq);
    case (src)
      0: trig_pwm_i = 1;
      1: trig_sw_i = 1;
      default: trig_ext_i = 1;
    endcase
    for (int j = 0; j <= len; j++) begin
      tick();
      if (j == 0) begin
        trig_pwm_i = 0; trig_sw_i = 0; trig_ext_i = 0;
        chk(ch_o == 3'(ch), "R1", "index at accept", ch_o, ch);
      end
      if (hold_o && j <= 6 + acq) begin nh++; if (fh < 0) fh = j; end
      if (a_upd_o && ja < 0) ja = j;
      if (b_upd_o && jb < 0) jb = j;
      if (irq_o && ji < 0) ji = j;
      trig_ext_i = 0; trig_sw_i = 0; trig_pwm_i = 0;
      if (kind == 1 && j == 3) begin trig_ext_i = 1; ch_i = 3'(nch); acq_i = 4'(15 - acq); end
      if (kind == 2 && j == 7 + acq) begin trig_sw_i = 1; ch_i = 3'(nch); end
      if (kind == 3 && j == 8 + acq) begin trig_pwm_i = 1; ch_i = 3'(nch); end
      if (kind == 4 && j == 2) begin ch_i = 3'(nch); acq_i = 4'(15 - acq); end
      if (kind == 3 && j == 9 + acq)
        chk(ch_o == 3'(nch), "R7", "request at first free edge accepted", ch_o, nch);
    end
    chk(fh == 3, "R3", "hold first high edge", fh, 3);
    chk(nh == 1 + acq, (kind == 1 || kind == 4) ? "R2" : "R3", "hold width", nh, 1 + acq);
    chk(ja == exp_a(acq), "R4", "A write edge", ja, exp_a(acq));
    chk(jb == exp_b(acq), "R5", "B write edge", jb, exp_b(acq));
    chk(ji == exp_i(acq), "R6", "irq set edge", ji, exp_i(acq));
    chk(irq_o == 1, "R6", "irq sticky", irq_o, 1);
    chk(ovf_o == (kind == 1 || kind == 2), "R7", "overflow flag", ovf_o, kind == 1 || kind == 2);
    if (kind != 3)
      chk(ch_o == 3'(ch), (kind == 4) ? "R2" : "R7", "index kept", ch_o, ch);
    repeat (40) tick();
    clear_flags();
  endtask

  task automatic run_cont(input int acq);
    int p, na = 0, nb = 0, nh = 0;
    int at[8];
    p = 3 + acq;
    acq_i = 4'(acq); ch_i = 3'd5; cont_i = 1; trig_sw_i = 1;
    for (int j = 0; j <= 2 * p + 16 + acq; j++) begin
      tick();
      trig_sw_i = 0; trig_ext_i = 0;
      if (hold_o) nh++;
      if (a_upd_o) begin if (na < 8) at[na] = j; na++; end
      if (b_upd_o) nb++;
      if (j == p + 1) trig_ext_i = 1;
      if (j == 3 * p - 1) cont_i = 0;
    end
    chk(na == 3, "R8", "continuous A write count", na, 3);
    chk(nb == 3, "R8", "continuous B write count", nb, 3);
    chk(nh == 3 * (1 + acq), "R8", "continuous hold clocks", nh, 3 * (1 + acq));
    chk(at[0] == exp_a(acq), "R8", "first A edge", at[0], exp_a(acq));
    chk(at[1] - at[0] == p, "R8", "A interval 1", at[1] - at[0], p);
    chk(at[2] - at[1] == p, "R8", "A interval 2", at[2] - at[1], p);
    chk(ovf_o == 1, "R7", "request during continuous run", ovf_o, 1);
    repeat (20) tick();
    clear_flags();
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk(hold_o == 0 && ch_o == 0 && res_a_o == 0 && res_b_o == 0, "R9", "outputs in reset", 0, 0);
    chk(a_upd_o == 0 && b_upd_o == 0 && irq_o == 0 && ovf_o == 0, "R9", "flags in reset", 0, 0);
    rst_n = 1;
    tick();
    chk(hold_o == 0 && irq_o == 0 && ovf_o == 0 && ch_o == 0, "R9", "outputs after reset", 0, 0);
    run_pair(3, 0, 0, 0);
    run_pair(6, 15, 1, 0);
    run_pair(1, 4, 2, 1);
    run_pair(2, 0, 0, 2);
    run_pair(7, 9, 1, 3);
    run_pair(4, 5, 2, 4);
    run_cont(0);
    run_cont(6);
    // set wins over clear on the interrupt
    begin
      int acq = 2;
      acq_i = 4'(acq); ch_i = 3'd0; trig_pwm_i = 1;
      for (int j = 0; j <= 14; j++) begin
        tick();
        trig_pwm_i = 0;
        irq_clr_i = (j == exp_i(acq) - 1);
      end
      irq_clr_i = 0;
      chk(irq_o == 1, "R6", "set wins over clear", irq_o, 1);
      repeat (20) tick();
      clear_flags();
    end
    for (int n = 0; n < 24; n++)
      run_pair(int'($urandom % 8), int'($urandom % 16), int'($urandom % 3), int'($urandom % 5));
    repeat (10) tick();
    chk(qa.size() == 0 && qb.size() == 0, "R4", "all samples written", qa.size(), 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule